// File: doc/BRIEF.md
# Clause-22 Management Interface Master

This block issues IEEE 802.3 clause-22 management read and write cycles to an external PHY over a two-wire management bus. It generates the management clock, shifts out the preamble and command frame, releases the shared data line for the turnaround on reads, and collects the sixteen returned data bits. Software sees four 32-bit registers on a simple synchronous write strobe and combinational read bus. The registers are a configuration word, a command word, a write-data word and a read-data word.

To write a PHY register, software first loads the write-data word. It then writes the command word with the PHY address, the register address, the write operation bit and the initiate bit set. To read, it writes the command word with the read operation bit and then polls the ready bit. Once ready returns to 1, the result is in the read-data word. The line driver is external: `mdioOut` is put on the pin while `mdioOe` is high. A board pull-up holds the pin high when nobody drives it.

Top module: `mdio_master`

## Requirements
- R1: After reset the ready bit (command word, address 1, bit 7) reads 1, `mdc` is low, `mdioOe` is low, and the configuration word (address 0) reads 29 in bits 5:0 (clock divider) with bit 6 (enable) clear.
- R2: A write to the command word that has bit 11 set is accepted when the enable is set, ready is 1, and exactly one of bit 15 (read) and bit 14 (write) is set. Ready reads 0 from the next cycle on. The command word reads back the PHY address in bits 28:24 and the register address in bits 20:16, and bit 11 always reads 0.
- R3: While a cycle runs, `mdc` has a period of 2×(divider+1) system clocks, and it rests low while idle.
- R4: A cycle sends 64 bits and then returns to idle with ready 1. The order is 32 ones, then 0 then 1, then the opcode (0,1 for write; 1,0 for read), then the PHY address MSB first, then the register address MSB first. A write then sends 1, 0 and the write-data word bits 15:0, MSB first (address 2).
- R5: `mdioOut` changes only after a falling edge of `mdc`, so each bit is stable across the rising edge that samples it.
- R6: On a read, `mdioOe` is low from bit 46 (first turnaround bit) to the end of the frame. Bits 48 to 63 are sampled on `mdc` rising edges, MSB first, into bits 15:0 of the read-data word (address 3). That word changes only when the cycle ends.
- R7: A read that no PHY answers, with the line pulled high, returns 0xFFFF.
- R8: While the enable is clear, a command with the initiate bit set is ignored: ready stays 1 and `mdc` does not toggle.
- R9: While a cycle runs, writes to any register are ignored. The cycle in flight and the configuration readback stay unchanged.
- R10: A command with both or neither of the read and write bits set is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register select: 0 config, 1 command, 2 write data, 3 read data |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for `busAddr` |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data to drive on the management data line |
| mdioOe | output | 1 | Drive enable for the management data line |
| mdioIn | input | 1 | Sampled level of the management data line |

## Verification
The assertions assume that `mdioIn` follows `mdioOut` whenever `mdioOe` is high, as a real pin does. They also assume that the divider changes only while the block is idle. Register writes are single-cycle strobes. The bench models the pin this way, including a pull-up and a PHY that drives only in the turnaround's second bit and the data bits. It issues configuration changes only between cycles, except in the test that checks that writes made mid-cycle are dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [1:0] ADDR_CFG   = 2'd0;
  localparam logic [1:0] ADDR_CMD   = 2'd1;
  localparam logic [1:0] ADDR_WDATA = 2'd2;
  localparam logic [1:0] ADDR_RDATA = 2'd3;

  localparam int CMD_PHY_LSB = 24;
  localparam int CMD_REG_LSB = 16;
  localparam int CMD_RD_BIT  = 15;
  localparam int CMD_WR_BIT  = 14;
  localparam int CMD_GO_BIT  = 11;
  localparam int CMD_RDY_BIT = 7;
  localparam int CFG_EN_BIT  = 6;

  typedef struct packed {
    logic busy;        // cycle in progress
    logic load;        // accept command, load frame
    logic shift;       // advance to next bit (falling edge)
    logic sample;      // rising edge of mdc
    logic sampleData;  // rising edge inside read data field
    logic finish;      // last falling edge of frame
    logic driveEn;     // master owns the data line
  } mdio_strobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W      = 6,
  parameter int FRAME_BITS = 64,
  parameter int TA_POS     = 46,
  parameter int DATA_POS   = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdReq,
  input  logic             isRead,
  input  logic             cfgEn,
  input  logic [DIV_W-1:0] cfgDiv,
  output mdio_strobe_t     st,
  output logic             mdc
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

  logic             busy;
  logic [DIV_W-1:0] halfCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             tick;

  assign tick = busy && (halfCnt == cfgDiv);

  always_comb begin
    st            = '0;
    st.busy       = busy;
    st.load       = cmdReq && !busy;
    st.sample     = tick && !mdc;
    st.sampleData = tick && !mdc && isRead && (bitIdx >= DATA_IDX);
    st.shift      = tick && mdc && (bitIdx != LAST_IDX);
    st.finish     = tick && mdc && (bitIdx == LAST_IDX);
    st.driveEn    = busy && !(isRead && (bitIdx >= TA_IDX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
      mdc     <= 1'b0;
    end else if (st.load) begin
      busy    <= 1'b1;
      halfCnt <= '0;
      bitIdx  <= '0;
      mdc     <= 1'b0;
    end else if (busy) begin
      if (tick) begin
        halfCnt <= '0;
        mdc     <= ~mdc;
        if (mdc) begin
          if (bitIdx == LAST_IDX) busy <= 1'b0;
          else bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc); // R3

  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cfgEn) |=> !busy); // R8

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isRead && bitIdx >= TA_IDX) |-> !st.driveEn); // R6

  AST_MDC_RISES_LOW_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $rose(mdc)) |-> $stable(bitIdx)); // R5
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int               DIV_W     = 6,
  parameter logic [DIV_W-1:0] DIV_RESET = 29,
  parameter int               PRE_BITS  = 32,
  parameter int               DATA_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic             mdioIn,
  output logic             mdioOut,
  input  mdio_strobe_t     st,
  output logic             cmdReq,
  output logic             isRead,
  output logic             cfgEn,
  output logic [DIV_W-1:0] cfgDiv
);
  localparam int FRAME_BITS = PRE_BITS + 16 + DATA_W;

  logic [DATA_W-1:0]     wdata;
  logic [DATA_W-1:0]     rdData;
  logic [DATA_W-1:0]     capReg;
  logic [4:0]            phyAddr;
  logic [4:0]            regAddr;
  logic                  opRd;
  logic                  opWr;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] frameNext;
  logic                  cmdWr;
  logic                  opOne;

  assign cmdWr  = busWr && (busAddr == ADDR_CMD) && !st.busy;
  assign opOne  = busWdata[CMD_RD_BIT] ^ busWdata[CMD_WR_BIT];
  assign cmdReq = cmdWr && busWdata[CMD_GO_BIT] && cfgEn && opOne;
  assign isRead = opRd;

  always_comb begin
    frameNext = {{PRE_BITS{1'b1}}, 2'b01,
                 (busWdata[CMD_RD_BIT] ? 2'b10 : 2'b01),
                 busWdata[CMD_PHY_LSB +: 5], busWdata[CMD_REG_LSB +: 5],
                 (busWdata[CMD_RD_BIT] ? 2'b11 : 2'b10),
                 (busWdata[CMD_RD_BIT] ? {DATA_W{1'b1}} : wdata)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgDiv   <= DIV_RESET;
      cfgEn    <= 1'b0;
      wdata    <= '0;
      phyAddr  <= '0;
      regAddr  <= '0;
      opRd     <= 1'b0;
      opWr     <= 1'b0;
      shiftReg <= '0;
      capReg   <= '0;
      rdData   <= '0;
    end else begin
      if (busWr && !st.busy) begin
        unique case (busAddr)
          ADDR_CFG: begin
            cfgDiv <= busWdata[DIV_W-1:0];
            cfgEn  <= busWdata[CFG_EN_BIT];
          end
          ADDR_WDATA: wdata <= busWdata[DATA_W-1:0];
          ADDR_CMD: begin
            phyAddr <= busWdata[CMD_PHY_LSB +: 5];
            regAddr <= busWdata[CMD_REG_LSB +: 5];
            opRd    <= busWdata[CMD_RD_BIT];
            opWr    <= busWdata[CMD_WR_BIT];
          end
          default: ;
        endcase
      end
      if (st.load) shiftReg <= frameNext;
      else if (st.shift) shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
      if (st.load) capReg <= '0;
      else if (st.sampleData) capReg <= {capReg[DATA_W-2:0], mdioIn};
      if (st.finish && opRd) rdData <= capReg;
    end
  end

  assign mdioOut = shiftReg[FRAME_BITS-1];

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_CFG: begin
        busRdata[DIV_W-1:0]  = cfgDiv;
        busRdata[CFG_EN_BIT] = cfgEn;
      end
      ADDR_CMD: begin
        busRdata[CMD_PHY_LSB +: 5] = phyAddr;
        busRdata[CMD_REG_LSB +: 5] = regAddr;
        busRdata[CMD_RD_BIT]       = opRd;
        busRdata[CMD_WR_BIT]       = opWr;
        busRdata[CMD_RDY_BIT]      = !st.busy;
      end
      ADDR_WDATA: busRdata[DATA_W-1:0] = wdata;
      default:    busRdata[DATA_W-1:0] = rdData;
    endcase
  end

  AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_CMD && busWdata[CMD_GO_BIT] && cfgEn && opOne
     && !st.busy) |=> st.busy); // R2

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (st.busy && $past(st.busy)) |-> ($stable(cfgDiv) && $stable(wdata))); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (st.busy && $past(st.busy)) |-> $stable(rdData)); // R6

  AST_BADOP_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!st.busy && busWr && busAddr == ADDR_CMD && !opOne) |=> !st.busy); // R10
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int               DIV_W     = 6,
  parameter logic [DIV_W-1:0] DIV_RESET = 29,
  parameter int               PRE_BITS  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = PRE_BITS + 16 + DATA_W;
  localparam int TA_POS     = PRE_BITS + 14;
  localparam int DATA_POS   = PRE_BITS + 16;

  mdio_strobe_t     st;
  logic             cmdReq;
  logic             isRead;
  logic             cfgEn;
  logic [DIV_W-1:0] cfgDiv;

  mdio_ctrl #(
    .DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS), .TA_POS(TA_POS), .DATA_POS(DATA_POS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .isRead(isRead),
    .cfgEn(cfgEn), .cfgDiv(cfgDiv), .st(st), .mdc(mdc)
  );

  mdio_datapath #(
    .DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .PRE_BITS(PRE_BITS), .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .st(st), .cmdReq(cmdReq), .isRead(isRead),
    .cfgEn(cfgEn), .cfgDiv(cfgDiv)
  );

  assign mdioOe = st.driveEn;

  AST_OUT_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (st.busy && $past(st.busy) && mdc) |-> $stable(mdioOut)); // R5

  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !st.busy |-> !mdioOe); // R1
endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  logic        phyEn = 1'b0;
  logic        phyDrive = 1'b0;
  logic        phyBit = 1'b1;
  logic [15:0] respVal = 16'h0;
  int          bitCnt = 0;
  int          riseCnt = 0;
  logic [63:0] frameBits = '0;
  logic [63:0] oeBits = '0;
  real         lastRise = -1.0;
  real         period = 0.0;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  assign mdioIn = mdioOe ? mdioOut : (phyDrive ? phyBit : 1'b1);

  mdio_master uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc) begin
    frameBits = {frameBits[62:0], mdioOut};
    oeBits    = {oeBits[62:0], mdioOe};
    if (lastRise >= 0.0) period = $realtime - lastRise;
    lastRise = $realtime;
    bitCnt++;
    riseCnt++;
  end

  always @(negedge mdc) begin
    if (phyEn && bitCnt == 47) begin
      phyDrive = 1'b1;
      phyBit   = 1'b0;
    end else if (phyEn && bitCnt >= 48 && bitCnt <= 63) begin
      phyDrive = 1'b1;
      phyBit   = respVal[63 - bitCnt];
    end else begin
      phyDrive = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitReady();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      busRead(2'd1, v);
      if (v[7]) break;
    end
  endtask

  function automatic logic [31:0] cmdWord(input logic [4:0] p, input logic [4:0] r,
                                          input logic rd, input logic wr, input logic go);
    return {3'b0, p, 3'b0, r, rd, wr, 2'b0, go, 11'b0};
  endfunction

  function automatic logic [63:0] wrFrame(input logic [4:0] p, input logic [4:0] r,
                                          input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic clearLog();
    bitCnt = 0; riseCnt = 0; lastRise = -1.0; period = 0.0;
    frameBits = '0; oeBits = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    busRead(2'd1, v);
    chk("R1 ready after reset", 64'(v[7]), 64'd1);
    busRead(2'd0, v);
    chk("R1 config reset value", 64'(v), 64'd29);
    chk("R1 mdc idle low", 64'(mdc), 64'd0);
    chk("R1 oe idle low", 64'(mdioOe), 64'd0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    clearLog();
    busWrite(2'd1, cmdWord(5'd1, 5'd1, 1'b0, 1'b1, 1'b1));
    busRead(2'd1, v);
    chk("R8 ready stays with enable clear", 64'(v[7]), 64'd1);
    repeat (200) @(negedge clk);
    chk("R8 no mdc edges with enable clear", 64'(riseCnt), 64'd0);
  endtask

  task automatic t_write(input logic [5:0] div);
    logic [31:0] v;
    busWrite(2'd0, {25'b0, 1'b1, div});
    busWrite(2'd2, 32'h0000_A5C3);
    clearLog();
    busWrite(2'd1, cmdWord(5'h13, 5'h0A, 1'b0, 1'b1, 1'b1));
    busRead(2'd1, v);
    chk("R2 ready drops and readback", 64'(v),
        64'(cmdWord(5'h13, 5'h0A, 1'b0, 1'b1, 1'b0)));
    waitReady();
    chk("R4 write frame bits", frameBits, wrFrame(5'h13, 5'h0A, 16'hA5C3));
    chk("R4 frame length", 64'(bitCnt), 64'd64);
    chk("R5 oe held for write", oeBits, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3 mdc period tenths ns", 64'(int'(period * 10.0)),
        64'(int'(2 * (div + 1)) * 50));
    repeat (20) @(negedge clk);
    chk("R3 mdc rests after cycle", 64'(riseCnt), 64'd64);
  endtask

  task automatic t_read(input logic withPhy, input logic [15:0] val, input logic [15:0] exp);
    logic [31:0] v;
    busWrite(2'd0, {25'b0, 1'b1, 6'd3});
    phyEn = withPhy; respVal = val;
    clearLog();
    busWrite(2'd1, cmdWord(5'h01, 5'h02, 1'b1, 1'b0, 1'b1));
    waitReady();
    phyEn = 1'b0;
    chk("R4 read header bits", 64'(frameBits[63:18]),
        64'({32'hFFFF_FFFF, 2'b01, 2'b10, 5'h01, 5'h02}));
    chk("R6 bus released from turnaround", oeBits, {46'h3FFF_FFFF_FFFF, 18'h0});
    busRead(2'd3, v);
    if (withPhy) chk("R6 read data captured", 64'(v), 64'(exp));
    else         chk("R7 undriven read returns all ones", 64'(v), 64'(exp));
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    busWrite(2'd0, {25'b0, 1'b1, 6'd1});
    busWrite(2'd2, 32'h0000_0F0F);
    clearLog();
    busWrite(2'd1, cmdWord(5'd3, 5'd4, 1'b0, 1'b1, 1'b1));
    repeat (30) @(negedge clk);
    busWrite(2'd1, cmdWord(5'd9, 5'd9, 1'b1, 1'b0, 1'b1));
    busWrite(2'd2, 32'h0000_FFFF);
    busWrite(2'd0, {25'b0, 1'b1, 6'd5});
    busRead(2'd0, v);
    chk("R9 config write ignored while busy", 64'(v), 64'h41);
    waitReady();
    chk("R9 frame unaffected by busy writes", frameBits, wrFrame(5'd3, 5'd4, 16'h0F0F));
    chk("R9 period unaffected", 64'(int'(period * 10.0)), 64'd200);
    busRead(2'd1, v);
    chk("R9 command readback kept", 64'(v), 64'(cmdWord(5'd3, 5'd4, 1'b0, 1'b1, 1'b0) | 32'h80));
  endtask

  task automatic t_badop();
    logic [31:0] v;
    busWrite(2'd0, {25'b0, 1'b1, 6'd1});
    clearLog();
    busWrite(2'd1, cmdWord(5'd2, 5'd2, 1'b1, 1'b1, 1'b1));
    busRead(2'd1, v);
    chk("R10 both op bits ignored", 64'(v[7]), 64'd1);
    busWrite(2'd1, cmdWord(5'd2, 5'd2, 1'b0, 1'b0, 1'b1));
    busRead(2'd1, v);
    chk("R10 no op bit ignored", 64'(v[7]), 64'd1);
    repeat (100) @(negedge clk);
    chk("R10 no mdc edges", 64'(riseCnt), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_write(6'd2);
    t_read(1'b1, 16'h1234, 16'h1234);
    t_read(1'b0, 16'h0000, 16'hFFFF);
    t_busy_ignore();
    t_badop();
    t_write(6'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule